// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from six on-chip sources and turns them into one vectored request for a small CPU core. The sources are a 128-µs tick, a 1.024-ms tick, two endpoint events (endpoint 0 and endpoint 1), a shared GPIO source and a wake-up event. Each source has a pending latch. An event sets the latch only while the source's enable bit is high. A global enable gates every request. At an instruction boundary, a fixed priority encoder picks the lowest-numbered pending enabled source. The block then offers that source's vector address to the CPU.

Vectors are two bytes apart in the low 16 bytes of program space. Address 0 is left for reset, so the six sources use addresses 0x02 to 0x0C. GPIO pins pass through a two-flop synchroniser and then an edge detector. Each pin has its own polarity and its own enable. All enabled pin edges merge into the single GPIO source, with no ranking among pins. The per-pin enables are inputs that the controller never changes, so acknowledging a GPIO interrupt leaves them as they were.

The control path is a two-state machine:
- In `ST_IDLE`, the TAKE transition fires when the instruction-done strobe, the global enable and at least one pending enabled source are all present in the same cycle. TAKE latches the winner and moves to `ST_OFFER`.
- In `ST_OFFER`, the request and the vector are held. The GRANT transition is the CPU's acknowledge. It clears the chosen latch and the global enable, and returns to `ST_IDLE`.
- A return-with-enable strobe sets the global enable again.

Top module: `irq_ctl`

## Requirements
- R1: After reset, the request output is 0, the vector output is 0, the global enable is 0 and all pending latches are clear.
- R2: An event on a source whose enable bit (src_en_i bit k) is 0 does not set that source's pending latch. Enabling the source afterwards produces no request.
- R3: Source index k (0=128-µs tick, 1=1.024-ms tick, 2=endpoint 0, 3=endpoint 1, 4=GPIO, 5=wake-up) has vector address 2*(k+1). When several sources are pending and enabled, the lowest index wins.
- R4: The request rises only on the clock edge after a cycle in which insn_done_i, the global enable and a pending enabled source are all present. Without insn_done_i, no request is offered.
- R5: While the global enable is 0, pending sources produce no request.
- R6: An acknowledge clears only the pending latch of the offered source. Other pending sources are offered later in priority order.
- R7: The edge that accepts an acknowledge clears the global enable and drops the request. A ret_ie_i pulse outside an acknowledge sets the global enable on the next edge.
- R8: For GPIO pin i, polarity bit 0 selects a high-to-low edge and polarity bit 1 selects a low-to-high edge. The opposite edge is ignored. Any accepted pin edge raises the GPIO source (vector 0x0A).
- R9: A pin whose pin_en_i bit is 0 raises no GPIO event. Per-pin enables are unaffected by acknowledge, so a later edge on the same enabled pin requests again.
- R10: A pin change that is applied before clock edge 1 sets the GPIO pending latch at edge 3. With insn_done_i and the global enable high, the request is visible after edge 4 and not before.
- R11: While a request is offered and not acknowledged, the request and the vector stay unchanged, even when a higher-priority source becomes pending.
- R12: If a new event from the offered source arrives in the same cycle as its acknowledge, the pending latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast_i | input | 1 | 128-µs tick event pulse (source 0) |
| tick_slow_i | input | 1 | 1.024-ms tick event pulse (source 1) |
| ep0_evt_i | input | 1 | Endpoint 0 event pulse (source 2) |
| ep1_evt_i | input | 1 | Endpoint 1 event pulse (source 3) |
| wake_evt_i | input | 1 | Wake-up event pulse (source 5) |
| pin_i | input | NPIN | Asynchronous GPIO pin levels |
| pin_pol_i | input | NPIN | Per-pin edge polarity: 0 falling, 1 rising |
| pin_en_i | input | NPIN | Per-pin interrupt enable |
| src_en_i | input | NSRC | Per-source enable, bit k for source k |
| insn_done_i | input | 1 | Instruction boundary strobe |
| irq_ack_i | input | 1 | CPU acknowledge of the offered vector |
| ret_ie_i | input | 1 | Return-with-enable: sets the global enable |
| irq_req_o | output | 1 | Vectored request to the CPU |
| vec_o | output | VEC_W | Vector address, 0 when no request |
| gie_o | output | 1 | Current global enable |

## Verification
Event inputs show up in the pending latch one edge later. TAKE needs one further edge, so a pulsed source is offered two edges after its pulse when the CPU is at a boundary. A GPIO pin change needs four edges, and the bench samples one negative edge before and one after that point. GRANT takes effect on the edge that samples the acknowledge. The global enable changes on the edge that samples ret_ie_i. A behavioural model in the bench advances on every rising edge with the same latencies. The request, the vector and the global enable are compared with that model on every falling edge. Directed checks are placed a fixed number of falling edges after each stimulus.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC  = 6;
    localparam int IDX_W = $clog2(NSRC);

    localparam int SRC_TICK_FAST = 0;
    localparam int SRC_TICK_SLOW = 1;
    localparam int SRC_EP0       = 2;
    localparam int SRC_EP1       = 3;
    localparam int SRC_GPIO      = 4;
    localparam int SRC_WAKE      = 5;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/irq_gpio_edge.sv
module irq_gpio_edge #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] pol_i,
    input  logic [NPIN-1:0] en_i,
    output logic            hit_o
);

    logic [NPIN-1:0] pin_hit;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic meta_q, sync_q, last_q;
        logic rise, fall;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise       = sync_q & ~last_q;
        assign fall       = ~sync_q & last_q;
        assign pin_hit[g] = en_i[g] & (pol_i[g] ? rise : fall);
    end

    assign hit_o = |pin_hit;

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar g = 0; g < N; g++) begin : g_latch
        logic pend_q;

        // a new gated event outranks a clear in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q <= 1'b0;
            else if (evt_i[g] && en_i[g])
                pend_q <= 1'b1;
            else if (clr_i[g])
                pend_q <= 1'b0;
        end

        assign pend_o[g] = pend_q;
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i])
                idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NPIN  = 8,
    parameter int VEC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast_i,
    input  logic             tick_slow_i,
    input  logic             ep0_evt_i,
    input  logic             ep1_evt_i,
    input  logic             wake_evt_i,
    input  logic [NPIN-1:0]  pin_i,
    input  logic [NPIN-1:0]  pin_pol_i,
    input  logic [NPIN-1:0]  pin_en_i,
    input  logic [NSRC-1:0]  src_en_i,
    input  logic             insn_done_i,
    input  logic             irq_ack_i,
    input  logic             ret_ie_i,
    output logic             irq_req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             gie_o
);

    localparam int VEC_STEP = 2;

    ctl_state_e       st_q, st_d;
    logic             gpio_hit;
    logic [NSRC-1:0]  evt, pend, armed, clr;
    logic             win_valid, take, grant;
    logic [IDX_W-1:0] win_idx, sel_q;
    logic             gie_q;

    assign evt = {wake_evt_i, gpio_hit, ep1_evt_i, ep0_evt_i, tick_slow_i, tick_fast_i};

    irq_gpio_edge #(.NPIN(NPIN)) u_gpio (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .pol_i (pin_pol_i),
        .en_i  (pin_en_i),
        .hit_o (gpio_hit)
    );

    irq_pend_bank #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .en_i   (src_en_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign armed = pend & src_en_i;

    irq_prio_enc #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
        .req_i   (armed),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    assign take  = (st_q == ST_IDLE) && insn_done_i && gie_q && win_valid;
    assign grant = (st_q == ST_OFFER) && irq_ack_i;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (take)  st_d = ST_OFFER;
            ST_OFFER: if (grant) st_d = ST_IDLE;
            default:             st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (take)
            sel_q <= win_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (grant)
            gie_q <= 1'b0;
        else if (ret_ie_i)
            gie_q <= 1'b1;
    end

    always_comb begin
        clr = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant && (sel_q == IDX_W'(i)))
                clr[i] = 1'b1;
        end
    end

    // outputs
    always_comb begin
        irq_req_o = 1'b0;
        vec_o     = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_OFFER: begin
                irq_req_o = 1'b1;
                vec_o     = VEC_W'((int'(sel_q) + 1) * VEC_STEP);
            end
            default: ;
        endcase
    end

    assign gie_o = gie_q;

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int VEC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_done_i,
    input logic             irq_ack_i,
    input logic             ret_ie_i,
    input logic             irq_req_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             gie_o
);

    p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (vec_o == '0));

    p_vec_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (vec_o >= VEC_W'(2) && vec_o <= VEC_W'(12) && !vec_o[0]));

    p_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> ($past(insn_done_i) && $past(gie_o)));

    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i) |=> (!gie_o && !irq_req_o));

    p_ret_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ie_i && !(irq_req_o && irq_ack_i)) |=> gie_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !irq_ack_i) |=> (irq_req_o && $stable(vec_o)));

endmodule

bind irq_ctl irq_ctl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_ctl_test.sv
`timescale 1ns/1ps
module irq_ctl_test;
    import irq_ctl_pkg::*;

    localparam int NPIN  = 8;
    localparam int VEC_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_fast = 0, tick_slow = 0, ep0 = 0, ep1 = 0, wake = 0;
    logic [NPIN-1:0] pin = '0, pol = '0, pen = '0;
    logic [NSRC-1:0] sen = '1;
    logic insn = 1'b1, ack = 1'b0, ret = 1'b0;
    logic irq_req;
    logic [VEC_W-1:0] vec;
    logic gie;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_ctl #(.NPIN(NPIN), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .tick_fast_i(tick_fast), .tick_slow_i(tick_slow),
        .ep0_evt_i(ep0), .ep1_evt_i(ep1), .wake_evt_i(wake),
        .pin_i(pin), .pin_pol_i(pol), .pin_en_i(pen), .src_en_i(sen),
        .insn_done_i(insn), .irq_ack_i(ack), .ret_ie_i(ret),
        .irq_req_o(irq_req), .vec_o(vec), .gie_o(gie)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit [NSRC-1:0] m_pend;
    bit            m_offer;
    int            m_sel;
    bit            m_gie;
    logic [NPIN-1:0] hist[$];
    logic [NPIN-1:0] h_old, h_new;
    bit [NSRC-1:0] m_ev;
    bit            m_gev, m_granted;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_offer = 0; m_sel = 0; m_gie = 0;
            hist = {NPIN'(0), NPIN'(0), NPIN'(0)};
        end else begin
            h_old = hist[0];
            h_new = hist[1];
            m_gev = 0;
            for (int i = 0; i < NPIN; i++) begin
                if (pen[i] && (pol[i] ? (h_new[i] && !h_old[i]) : (!h_new[i] && h_old[i])))
                    m_gev = 1;
            end
            m_ev = {wake, m_gev, ep1, ep0, tick_slow, tick_fast};
            m_granted = 0;
            if (!m_offer) begin
                if (insn && m_gie && ((m_pend & sen) != 0)) begin
                    for (int k = NSRC - 1; k >= 0; k--)
                        if (m_pend[k] && sen[k]) m_sel = k;
                    m_offer = 1;
                end
            end else if (ack) begin
                m_pend[m_sel] = 0;
                m_gie = 0;
                m_offer = 0;
                m_granted = 1;
            end
            if (ret && !m_granted) m_gie = 1;
            m_pend = m_pend | (m_ev & sen);
            void'(hist.pop_front());
            hist.push_back(pin);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq_req == m_offer, "R4 model request", int'(irq_req), int'(m_offer));
            chk(int'(vec) == (m_offer ? 2 * (m_sel + 1) : 0), "R3 model vector",
                int'(vec), m_offer ? 2 * (m_sel + 1) : 0);
            chk(gie == m_gie, "R7 model global enable", int'(gie), int'(m_gie));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
    endtask

    task automatic expect_req(input bit r, input int v, input string tag);
        chk(irq_req == r, tag, int'(irq_req), int'(r));
        if (r) chk(int'(vec) == v, tag, int'(vec), v);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(irq_req == 1'b0, "R1 request after reset", int'(irq_req), 0);
        chk(vec == '0, "R1 vector after reset", int'(vec), 0);
        chk(gie == 1'b0, "R1 global enable after reset", int'(gie), 0);

        // R5 global enable gates requests
        @(negedge clk); tick_fast = 1; @(negedge clk); tick_fast = 0;
        tick(4);
        expect_req(0, 0, "R5 no request while global enable low");

        do_ret();
        tick(2);
        chk(gie == 1'b1, "R7 ret sets global enable", int'(gie), 1);
        expect_req(1, 2, "R3 fast tick vector 0x02");
        do_ack();
        chk(gie == 1'b0, "R7 ack clears global enable", int'(gie), 0);
        expect_req(0, 0, "R7 request drops on ack");
        do_ret();
        tick(3);
        expect_req(0, 0, "R6 acked source cleared");

        // R2 disabled source ignored
        sen[SRC_EP1] = 1'b0;
        @(negedge clk); ep1 = 1; @(negedge clk); ep1 = 0;
        tick(2);
        sen[SRC_EP1] = 1'b1;
        tick(4);
        expect_req(0, 0, "R2 disabled event not latched");

        // R4 boundary and R3 priority
        insn = 1'b0;
        @(negedge clk); ep1 = 1; ep0 = 1; wake = 1;
        @(negedge clk); ep1 = 0; ep0 = 0; wake = 0;
        tick(3);
        expect_req(0, 0, "R4 no request without boundary");
        insn = 1'b1;
        tick(2);
        expect_req(1, 6, "R3 endpoint 0 wins over endpoint 1 and wake");

        // R11 hold while offered
        @(negedge clk); tick_fast = 1; @(negedge clk); tick_fast = 0;
        tick(2);
        expect_req(1, 6, "R11 vector held despite higher priority");
        do_ack(); do_ret(); tick(2);
        expect_req(1, 2, "R6 fast tick taken next");
        do_ack(); do_ret(); tick(2);
        expect_req(1, 8, "R6 endpoint 1 still pending");
        do_ack(); do_ret(); tick(2);
        expect_req(1, 12, "R3 wake-up vector 0x0C");
        do_ack();

        // R12 set wins over clear
        do_ret();
        @(negedge clk); ep0 = 1; @(negedge clk); ep0 = 0;
        tick(2);
        expect_req(1, 6, "R12 endpoint 0 offered");
        @(negedge clk); ack = 1; ep0 = 1;
        @(negedge clk); ack = 0; ep0 = 0;
        do_ret();
        tick(2);
        expect_req(1, 6, "R12 event during ack kept pending");
        do_ack();

        // R8 polarity
        do_ret();
        pen[0] = 1'b1; pol[0] = 1'b0;
        @(negedge clk); pin[0] = 1'b1;
        tick(6);
        expect_req(0, 0, "R8 rising edge ignored with polarity 0");
        @(negedge clk); pin[0] = 1'b0;
        tick(6);
        expect_req(1, 10, "R8 falling edge with polarity 0");
        do_ack(); do_ret();
        pen[2] = 1'b1; pol[2] = 1'b1;
        @(negedge clk); pin[2] = 1'b1;
        tick(6);
        expect_req(1, 10, "R8 rising edge with polarity 1");
        do_ack(); do_ret();
        @(negedge clk); pin[2] = 1'b0;
        tick(6);
        expect_req(0, 0, "R8 falling edge ignored with polarity 1");

        // R9 pin enable
        @(negedge clk); pin[5] = 1'b1;
        tick(3);
        @(negedge clk); pin[5] = 1'b0;
        tick(6);
        expect_req(0, 0, "R9 disabled pin ignored");

        // R9 enables survive ack, R10 latency
        @(negedge clk); pin[0] = 1'b1;
        tick(4);
        @(negedge clk); pin[0] = 1'b0;
        tick(3);
        expect_req(0, 0, "R10 not yet offered after three edges");
        tick(1);
        expect_req(1, 10, "R10 offered after fourth edge, R9 pin still enabled");
        do_ack();
        tick(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule